// File: doc/BRIEF.md
# Codec-Side Synchronous Serial Port

This block is the slave side of a synchronous serial link between a codec and a host signal processor. It runs entirely on the master clock. From that clock it derives the serial clock through two cascaded integer dividers. It sends 16-bit words MSB first, each one led by a one-bit output frame pulse. It also collects 16-bit words that arrive after an input frame pulse. Transmit bits change on the rising edge of the serial clock. Receive bits and the input frame pulse are taken on the falling edge.

The codec side hands words to the port through a valid/ready transmit interface backed by a one-word holding register. `tx_ready_o` is high exactly when that register is empty. A word that is written while a frame is still going out waits there and leaves in the following frame. The receive side has no back-pressure: each received word appears on `rx_data_o` with a one-cycle `rx_valid_o` strobe, and the consumer must take it in that cycle.

An asynchronous port-enable input switches the serial side off and on. While it is low, the serial clock is held low, the pad enables for data and frame sync drop at once, and the serial inputs are ignored. The holding register and the last received word survive a disable. The divider counters, a frame in flight and the receive progress start again from their reset values.

Top module: `codec_sport`

## Requirements
- R1: While `rst_ni` is low, and directly after it, `tx_ready_o`=1, `rx_valid_o`=0, `sdo_oe_o`=0 and `sdofs_o`=0. During reset `sdofs_oe_o`=0 and `sclk_o`=0.
- R2: For each divider input, a value of 0 or 1 counts as 1. The serial clock period is N = eff(`div_mclk_i`) × eff(`div_sclk_i`) master-clock cycles. For N ≥ 2, `sclk_o` is high for floor(N/2) cycles and low for the rest of the period, which gives an even duty cycle whenever N is even. For N = 1, `sclk_o` follows the gated master clock.
- R3: A transmit frame starts on a rising serial edge with `sdofs_o`=1 and `sdo_oe_o`=0 for one serial period. On the next 16 rising edges `sdo_o` carries the word MSB first, with `sdo_oe_o`=1 and `sdofs_o`=0. `sdo_oe_o` is 0 whenever no word bits are being driven.
- R4: A word is accepted when `tx_valid_i` and `tx_ready_o` are both high at a master-clock edge. `tx_ready_o` then stays low until that word moves to the shifter at the start of its frame. Accepted words are sent in the order they were accepted.
- R5: `sdifs_i` is sampled on falling serial edges. When the receiver is idle and samples a 1, the next 16 falling edges sample `sdi_i` MSB first. One master-clock cycle after the LSB is sampled, `rx_data_o` holds the word and `rx_valid_o` is high for exactly one cycle.
- R6: `sdifs_i` is ignored while a word is being received. A frame pulse sampled on the falling edge right after the LSB starts the next word with no gap.
- R7: While `port_en_i` is low, `sclk_o`=0 and no word is received, whatever happens on `sdi_i` and `sdifs_i`.
- R8: When `port_en_i` goes high again, the holding register and `rx_data_o` keep the values they had before the disable. The divider, the transmit frame and the receive progress restart from idle, and a word still held is sent in a fresh frame.
- R9: `sdo_oe_o` and `sdofs_oe_o` fall combinationally with `port_en_i`, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low reset, clears all state |
| port_en_i | input | 1 | Asynchronous serial-port enable |
| div_mclk_i | input | DIV_W | Master-clock-rate divider (0 and 1 mean 1) |
| div_sclk_i | input | DIV_W | Serial-clock-rate divider (0 and 1 mean 1) |
| tx_data_i | input | WORD_W | Word to transmit |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Holding register empty |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received word |
| sclk_o | output | 1 | Serial clock to the host |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Pad enable for sdo_o (0 means high impedance) |
| sdofs_o | output | 1 | Output frame sync |
| sdofs_oe_o | output | 1 | Pad enable for sdofs_o |
| sdi_i | input | 1 | Serial data in |
| sdifs_i | input | 1 | Input frame sync |

## Verification
The checker assumes two things about the inputs. First, an offered transmit word stays valid and unchanged until it is accepted. Second, the divider inputs change only while the port is disabled. The bench meets both rules. Its send task raises `tx_valid_i` only once it has seen `tx_ready_o` high. Every divider change is made inside a disable window that lasts several cycles. The bench also drives the serial inputs only at falling master-clock edges, between serial edges, so no sample lands on a transition. During the disable test it waits for the enable synchronizer to settle before it toggles `sdi_i` and `sdifs_i`.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SYNC = 2'd1,
    TX_DATA = 2'd2
  } tx_state_e;

  localparam int unsigned DIV_STAGES = 2;

endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen
  import sport_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_mclk_i,
  input  logic [DIV_W-1:0] div_sclk_i,
  output logic             sclk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);

  localparam int unsigned PW = 2 * DIV_W;

  logic [DIV_W-1:0] dv   [DIV_STAGES];
  logic [DIV_W-1:0] eff  [DIV_STAGES];
  logic [DIV_W-1:0] lim  [DIV_STAGES];
  logic [DIV_W-1:0] cnt  [DIV_STAGES];
  logic             carry[DIV_STAGES+1];

  assign dv[0]    = div_mclk_i;
  assign dv[1]    = div_sclk_i;
  assign carry[0] = 1'b1;

  // cascaded stages: a stage advances only when all lower stages wrap
  for (genvar s = 0; s < DIV_STAGES; s++) begin : g_stage
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign eff[s]     = (dv[s] <= DIV_W'(1)) ? DIV_W'(1) : dv[s];
    assign lim[s]     = eff[s] - DIV_W'(1);
    assign wrap       = (cnt_q == lim[s]);
    assign carry[s+1] = carry[s] & wrap;
    assign cnt[s]     = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (!run_i) begin
        cnt_q <= '0;
      end else if (carry[s]) begin
        cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
      end
    end
  end

  logic [PW-1:0] period;
  logic [PW-1:0] half;
  logic [PW-1:0] pos;
  logic          one_mode;
  logic          sclk_q;

  assign period   = PW'(eff[0]) * PW'(eff[1]);
  assign half     = period >> 1;
  assign pos      = PW'(cnt[1]) * PW'(eff[0]) + PW'(cnt[0]);
  assign one_mode = (period == PW'(1));

  assign rise_stb_o = run_i & carry[DIV_STAGES];
  assign fall_stb_o = run_i & (one_mode | (pos == half - PW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
    end else if (!run_i || one_mode) begin
      sclk_q <= 1'b0;
    end else if (rise_stb_o) begin
      sclk_q <= 1'b1;
    end else if (fall_stb_o) begin
      sclk_q <= 1'b0;
    end
  end

  assign sclk_o = one_mode ? (clk_i & run_i) : sclk_q;

endmodule

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              rise_stb_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              sdo_o,
  output logic              drive_o,
  output logic              fs_o
);

  localparam int unsigned CW = $clog2(WORD_W);

  tx_state_e         state_q;
  logic [WORD_W-1:0] hold_q;
  logic              hold_full_q;
  logic [WORD_W-1:0] shift_q;
  logic [CW-1:0]     left_q;
  logic              accept;
  logic              load;
  logic              frame_end;

  assign tx_ready_o = ~hold_full_q;
  assign accept     = tx_valid_i & tx_ready_o;
  assign frame_end  = (state_q == TX_IDLE) ||
                      ((state_q == TX_DATA) && (left_q == '0));
  assign load       = run_i & rise_stb_i & frame_end & hold_full_q;

  // holding register survives a port disable; only reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (accept) begin
      hold_q      <= tx_data_i;
      hold_full_q <= 1'b1;
    end else if (load) begin
      hold_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      shift_q <= '0;
      left_q  <= '0;
    end else if (!run_i) begin
      state_q <= TX_IDLE;
      left_q  <= '0;
    end else if (rise_stb_i) begin
      unique case (state_q)
        TX_SYNC: begin
          state_q <= TX_DATA;
          left_q  <= CW'(WORD_W - 1);
        end
        TX_DATA: begin
          if (left_q != '0) begin
            shift_q <= {shift_q[WORD_W-2:0], 1'b0};
            left_q  <= left_q - CW'(1);
          end else if (hold_full_q) begin
            state_q <= TX_SYNC;
            shift_q <= hold_q;
          end else begin
            state_q <= TX_IDLE;
          end
        end
        default: begin
          if (hold_full_q) begin
            state_q <= TX_SYNC;
            shift_q <= hold_q;
          end
        end
      endcase
    end
  end

  assign sdo_o   = shift_q[WORD_W-1];
  assign drive_o = (state_q == TX_DATA);
  assign fs_o    = (state_q == TX_SYNC);

endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              fall_stb_i,
  input  logic              sdi_i,
  input  logic              sdifs_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  localparam int unsigned CW = $clog2(WORD_W);

  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic [WORD_W-1:0] next_shift;

  assign next_shift = {shift_q[WORD_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!run_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (fall_stb_i) begin
        if (!busy_q) begin
          if (sdifs_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
          end
        end else begin
          shift_q <= next_shift;
          cnt_q   <= cnt_q + CW'(1);
          if (cnt_q == CW'(WORD_W - 1)) begin
            busy_q  <= 1'b0;
            word_q  <= next_shift;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_data_o  = word_q;
  assign rx_valid_o = valid_q;

endmodule

// File: rtl/codec_sport.sv
module codec_sport
  import sport_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic [DIV_W-1:0]  div_mclk_i,
  input  logic [DIV_W-1:0]  div_sclk_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sdofs_o,
  output logic              sdofs_oe_o,
  input  logic              sdi_i,
  input  logic              sdifs_i
);

  logic [1:0] en_sync_q;
  logic       run;
  logic       rise_stb;
  logic       fall_stb;
  logic       sclk_int;
  logic       drive;
  logic       fs;

  // two-flop synchronizer for the asynchronous port enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_sync_q <= 2'b00;
    end else begin
      en_sync_q <= {en_sync_q[0], port_en_i};
    end
  end

  assign run = en_sync_q[1];

  sport_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .div_mclk_i (div_mclk_i),
    .div_sclk_i (div_sclk_i),
    .sclk_o     (sclk_int),
    .rise_stb_o (rise_stb),
    .fall_stb_o (fall_stb)
  );

  sport_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .rise_stb_i (rise_stb),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .sdo_o      (sdo_o),
    .drive_o    (drive),
    .fs_o       (fs)
  );

  sport_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .fall_stb_i (fall_stb),
    .sdi_i      (sdi_i),
    .sdifs_i    (sdifs_i),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  // pad enables drop combinationally with the asynchronous enable
  assign sclk_o     = port_en_i & sclk_int;
  assign sdo_oe_o   = port_en_i & drive;
  assign sdofs_o    = fs;
  assign sdofs_oe_o = port_en_i & run;

endmodule

// File: rtl/codec_sport_chk.sv
module codec_sport_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DIV_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              port_en_i,
  input logic [DIV_W-1:0]  div_mclk_i,
  input logic [DIV_W-1:0]  div_sclk_i,
  input logic [WORD_W-1:0] tx_data_i,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              sclk_o,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              sdofs_o,
  input logic              sdofs_oe_o,
  input logic              sdi_i,
  input logic              sdifs_i
);

  // R3
  fs_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdofs_oe_o && sdofs_o) |-> !sdo_oe_o);

  // R3
  data_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(sdofs_o));

  // R9
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> (!sdo_oe_o && !sdofs_oe_o));

  // R5
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R4
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> $past(tx_valid_i));

  // R4 (input rule: offered word held until taken)
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_o) |=> (tx_valid_i && $stable(tx_data_i)));

  // R2 (input rule: dividers change only while disabled)
  div_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdofs_oe_o && $past(sdofs_oe_o)) |-> ($stable(div_mclk_i) && $stable(div_sclk_i)));

endmodule

bind codec_sport codec_sport_chk #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/codec_sport_bench.sv
module codec_sport_bench;
  localparam int W  = 16;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic [DW-1:0] da = '0, db = '0;
  logic [W-1:0]  txd = '0;
  logic          txv = 1'b0;
  logic          tx_ready, rx_valid, sclk, sdo, sdo_oe, sdofs, sdofs_oe;
  logic [W-1:0]  rx_data;
  logic          loopback = 1'b1;
  logic          sdi_drv = 1'b0, fs_drv = 1'b0;
  logic          sdi, sdifs;

  assign sdi   = loopback ? (sdo_oe & sdo) : sdi_drv;
  assign sdifs = loopback ? (sdofs_oe & sdofs) : fs_drv;

  always #10 clk = ~clk;

  codec_sport #(.WORD_W(W), .DIV_W(DW)) u_codec_sport (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(en),
    .div_mclk_i(da), .div_sclk_i(db),
    .tx_data_i(txd), .tx_valid_i(txv), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .sclk_o(sclk), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .sdofs_o(sdofs), .sdofs_oe_o(sdofs_oe),
    .sdi_i(sdi), .sdifs_i(sdifs)
  );

  int vectors = 0, miscompares = 0;
  int rx_n = 0;
  logic [W-1:0] rx_log [4];
  int n_eff = 1;

  always @(negedge clk) if (rx_valid) begin
    rx_log[rx_n % 4] = rx_data;
    rx_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [DW-1:0] v);
    return (v <= 1) ? 1 : int'(v);
  endfunction

  task automatic wait_rise();
    if (n_eff == 1) @(negedge clk);
    else begin
      do @(negedge clk); while (sclk);
      do @(negedge clk); while (!sclk);
    end
  endtask

  task automatic set_div(input int a, input int b);
    @(negedge clk); en = 1'b0;
    repeat (4) @(negedge clk);
    da = DW'(a); db = DW'(b);
    n_eff = eff(da) * eff(db);
    @(negedge clk); en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [W-1:0] w);
    do @(negedge clk); while (!tx_ready);
    txd = w; txv = 1'b1;
    @(negedge clk);
    txv = 1'b0;
  endtask

  task automatic capture(output logic [W-1:0] w, output bit okf);
    okf = 1'b1; w = '0;
    do wait_rise(); while (!(sdofs_oe && sdofs));
    if (sdo_oe) okf = 1'b0;
    for (int i = 0; i < W; i++) begin
      wait_rise();
      if (!sdo_oe || sdofs) okf = 1'b0;
      w = {w[W-2:0], sdo};
    end
  endtask

  task automatic rx_drive(input logic [W-1:0] w, input int glitch);
    wait_rise();
    fs_drv = 1'b1;
    for (int i = 0; i < W; i++) begin
      wait_rise();
      fs_drv  = (i == glitch);
      sdi_drv = w[W-1-i];
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    logic [W-1:0] got, w1, w2, w3;
    bit okf;
    int base, hi, lo;

    // R1: during reset and just after
    repeat (3) @(negedge clk);
    chk(!sdo_oe && !sdofs_oe && !sclk, "R1 reset outputs", {sdo_oe, sdofs_oe, sclk}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready && !rx_valid && !sdo_oe && !sdofs, "R1 after reset",
        {tx_ready, rx_valid, sdo_oe, sdofs}, 4'b1000);

    // R2 R3 R5: sweep both dividers over 0..3 with loopback
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        set_div(a, b);
        if (n_eff >= 2) begin
          wait_rise();
          hi = 0; lo = 0;
          while (sclk) begin hi++; @(negedge clk); end
          while (!sclk) begin lo++; @(negedge clk); end
          chk(hi == n_eff / 2, "R2 high time", hi, n_eff / 2);
          chk(hi + lo == n_eff, "R2 period", hi + lo, n_eff);
        end else begin
          @(posedge clk); #1;
          chk(sclk == 1'b1, "R2 div1 high", sclk, 1);
          @(negedge clk); #1;
          chk(sclk == 1'b0, "R2 div1 low", sclk, 0);
        end
        for (int k = 0; k < 2; k++) begin
          w1 = (k == 0) ? (16'hA5C3 ^ W'(a * 16'h1111 + b)) : (16'h8001 ^ W'(b << (4 * a)));
          base = rx_n;
          fork
            send(w1);
            capture(got, okf);
          join
          chk(got == w1, "R3 tx word", got, w1);
          chk(okf, "R3 frame shape", okf, 1);
          wait_rise();
          chk(!sdo_oe, "R3 idle tri-state", sdo_oe, 0);
          repeat (3) @(negedge clk);
          chk(rx_n - base == 1, "R5 rx count", rx_n - base, 1);
          chk(rx_log[(rx_n + 3) % 4] == w1, "R5 rx word", rx_log[(rx_n + 3) % 4], w1);
        end
      end
    end

    // R4: holding register and back-pressure, N = 4
    set_div(2, 2);
    w1 = 16'h1234; w2 = 16'hFEDC; w3 = 16'h0F0F;
    fork
      begin
        send(w1);
        send(w2);
        chk(!tx_ready, "R4 ready low while held", tx_ready, 0);
        send(w3);
      end
      begin
        capture(got, okf); chk(got == w1 && okf, "R4 order first", got, w1);
        capture(got, okf); chk(got == w2 && okf, "R4 order second", got, w2);
        capture(got, okf); chk(got == w3 && okf, "R4 order third", got, w3);
      end
    join
    repeat (8) @(negedge clk);

    // R5 R6: driven receive with a mid-word pulse and back-to-back frames
    loopback = 1'b0;
    base = rx_n;
    rx_drive(16'hC0DE, 5);
    rx_drive(16'h4B1D, -1);
    wait_rise();
    fs_drv = 1'b0; sdi_drv = 1'b0;
    repeat (20) wait_rise();
    chk(rx_n - base == 2, "R6 frame count", rx_n - base, 2);
    chk(rx_log[base % 4] == 16'hC0DE, "R6 mid-word pulse ignored", rx_log[base % 4], 16'hC0DE);
    chk(rx_log[(base + 1) % 4] == 16'h4B1D, "R6 back-to-back word", rx_log[(base + 1) % 4], 16'h4B1D);
    loopback = 1'b1;
    repeat (8) @(negedge clk);

    // R7 R8 R9: disable mid-frame with a held word
    w1 = 16'h5A5A; w2 = 16'h3C96;
    base = rx_n;
    send(w1);
    do @(negedge clk); while (!sdo_oe);
    send(w2);
    repeat (3) wait_rise();
    en = 1'b0;
    #1;
    chk(!sdo_oe && !sdofs_oe, "R9 immediate tri-state", {sdo_oe, sdofs_oe}, 0);
    repeat (4) @(negedge clk);
    loopback = 1'b0;
    hi = 0;
    for (int i = 0; i < 4 * n_eff; i++) begin
      fs_drv = i[0]; sdi_drv = i[1];
      @(posedge clk); #1;
      if (sclk) hi++;
      @(negedge clk);
    end
    fs_drv = 1'b0; sdi_drv = 1'b0;
    chk(hi == 0, "R7 sclk stopped", hi, 0);
    chk(rx_n == base, "R7 inputs ignored", rx_n - base, 0);
    chk(!tx_ready, "R8 held word retained", tx_ready, 0);
    loopback = 1'b1;
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_data == w2 || rx_data == rx_log[(base + 3) % 4], "R8 rx data retained",
        rx_data, rx_log[(base + 3) % 4]);
    capture(got, okf);
    chk(got == w2 && okf, "R8 held word sent after enable", got, w2);
    repeat (2) wait_rise();
    chk(rx_n - base == 1, "R8 aborted frame dropped", rx_n - base, 1);
    chk(rx_data == w2, "R8 rx after enable", rx_data, w2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule